// File: doc/BRIEF.md
# GCD Sequencer Controller

This block is the control unit that steps a greatest-common-divisor datapath through its work. The datapath holds two operand registers, an adder/subtractor with shift, and a bit-position counter. It reports six status flags. The controller is an eight-state Moore machine. Every state drives one fixed microinstruction: a word of enable bits, one bit per microoperation. The datapath executes that word during the cycle.

A run begins in the idle state when the start input is seen high. The controller loads the operands and orders them. It then aligns the divisor to the top bit and runs restoring shift-subtract steps to form a remainder. It swaps and repeats until the remainder is zero, and then raises the ready bit for a single cycle before it returns to idle. The outputs are decoded from the registered state alone.

Top module: `gcd_seq_ctl`

## Requirements
- R1: A clock edge with `rst_ni` low puts the controller in idle, and in idle every bit of `uop_o` is 0.
- R2: In idle the controller stays idle while `start_i` is 0, whatever the status inputs are. With `start_i` high it moves to the load state, whose word is 0x0A3 (bits 7, 5, 1, 0).
- R3: From load the next state is chosen by priority. `equal_i` leads to done. Otherwise `less_i` leads to swap. Otherwise `msb_i` leads to subtract. Otherwise the next state is normalize.
- R4: The swap state drives 0x053 (bits 6, 4, 1, 0). It goes to subtract when `msb_i` is 1 and to normalize otherwise.
- R5: The normalize state drives 0x206 (bits 9, 2, 1). It holds while `msb_i` is 0 and goes to subtract when `msb_i` is 1.
- R6: The subtract state drives 0x101 (bits 8, 0). `neg_i`=1 leads to restore, whatever the other flags are. With `neg_i`=0 the next state is step when `cnt_zero_i`=0. It is done when `cnt_zero_i`=1 and `rem_zero_i`=1, and swap when `cnt_zero_i`=1 and `rem_zero_i`=0.
- R7: The restore state drives 0x001 (bit 0 only). It goes to step when `cnt_zero_i`=0. When `cnt_zero_i`=1 it goes to done if `rem_zero_i`=1 and to swap otherwise.
- R8: The step state drives 0x30E (bits 9, 8, 3, 2, 1) and always goes to subtract after one cycle.
- R9: The done state drives 0x400 (bit 10, the ready bit, alone) for exactly one cycle and then returns to idle.
- R10: `uop_o` changes only at a clock edge. A change on any input during a cycle leaves `uop_o` as it was until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a computation |
| equal_i | input | 1 | Operand registers hold equal values |
| less_i | input | 1 | First operand register is smaller than the second |
| msb_i | input | 1 | Divisor register has its top data bit set |
| neg_i | input | 1 | Partial remainder is negative |
| cnt_zero_i | input | 1 | Shift counter is zero |
| rem_zero_i | input | 1 | Remainder register is zero |
| uop_o | output | 11 | Microoperation enables, bit n is microoperation n; bit 10 is ready |

## Verification
The bench builds the block with its package defaults: eleven enable bits and eight states. Each state has a unique word, so the bench can tell which state the controller is in from `uop_o` alone, and every branch can be checked at the ports. The bench takes each guarded branch in turn and sets conflicting flags to test the branch priorities. It also toggles inputs in the middle of a cycle to show that the Moore outputs do not follow them.

// File: rtl/gcd_seq_pkg.sv
// Package: shared types and constants for the GCD sequencer controller.
// Assumes the state order below; the enable word of each state is computed
// by uop_word and is the single source for the output decode.
package gcd_seq_pkg;

    localparam int STATE_W    = 3;
    localparam int NUM_STATES = 1 << STATE_W;
    localparam int UOP_W      = 11;

    // Enable bit positions, as decoded by the datapath.
    localparam int U_RG1_EN   = 0;
    localparam int U_RG2_EN   = 1;
    localparam int U_CNT_EN   = 2;
    localparam int U_CNT_DOWN = 3;
    localparam int U_RG2_SELA = 4;
    localparam int U_RG2_SELB = 5;
    localparam int U_RG1_SELA = 6;
    localparam int U_RG1_SELB = 7;
    localparam int U_ALU_OPA  = 8;
    localparam int U_ALU_OPB  = 9;
    localparam int U_READY    = 10;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_SWAP    = 3'd2,
        ST_NORM    = 3'd3,
        ST_SUB     = 3'd4,
        ST_RESTORE = 3'd5,
        ST_STEP    = 3'd6,
        ST_DONE    = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic rem_zero;
        logic cnt_zero;
        logic neg;
        logic msb;
        logic less;
        logic equal;
    } seq_status_t;

    // Microinstruction attached to each state.
    function automatic logic [UOP_W-1:0] uop_word(input seq_state_t s);
        logic [UOP_W-1:0] w;
        w = '0;
        case (s)
            ST_LOAD: begin
                w[U_RG1_SELB] = 1'b1; w[U_RG2_SELB] = 1'b1;
                w[U_RG2_EN]   = 1'b1; w[U_RG1_EN]   = 1'b1;
            end
            ST_SWAP: begin
                w[U_RG1_SELA] = 1'b1; w[U_RG2_SELA] = 1'b1;
                w[U_RG2_EN]   = 1'b1; w[U_RG1_EN]   = 1'b1;
            end
            ST_NORM: begin
                w[U_ALU_OPB] = 1'b1; w[U_CNT_EN] = 1'b1; w[U_RG2_EN] = 1'b1;
            end
            ST_SUB: begin
                w[U_ALU_OPA] = 1'b1; w[U_RG1_EN] = 1'b1;
            end
            ST_RESTORE: begin
                w[U_RG1_EN] = 1'b1;
            end
            ST_STEP: begin
                w[U_ALU_OPB]  = 1'b1; w[U_ALU_OPA] = 1'b1; w[U_CNT_DOWN] = 1'b1;
                w[U_CNT_EN]   = 1'b1; w[U_RG2_EN]  = 1'b1;
            end
            ST_DONE: begin
                w[U_READY] = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    // For one enable bit, the set of states (one bit per state) that drive it.
    function automatic logic [NUM_STATES-1:0] uop_mask(input int bit_idx);
        logic [NUM_STATES-1:0] m;
        logic [UOP_W-1:0]      w;
        m = '0;
        for (int s = 0; s < NUM_STATES; s++) begin
            w    = uop_word(seq_state_t'(s[STATE_W-1:0]));
            m[s] = w[bit_idx];
        end
        return m;
    endfunction

endpackage

// File: rtl/gcd_seq_next.sv
// Next-state logic: picks the following state from the present state,
// the start request and the datapath status flags. Purely combinational;
// assumes the flags are stable before the clock edge.
module gcd_seq_next
    import gcd_seq_pkg::*;
(
    input  seq_state_t  state_i,
    input  logic        start_i,
    input  seq_status_t status_i,
    output seq_state_t  next_o
);

    // Common exit once the remainder is final: finish or swap and repeat.
    seq_state_t after_remainder;

    // Purpose: choose the exit taken when the remainder loop is complete.
    always_comb begin
        if (!status_i.cnt_zero)     after_remainder = ST_STEP;
        else if (status_i.rem_zero) after_remainder = ST_DONE;
        else                        after_remainder = ST_SWAP;
    end

    // Purpose: the guarded transition list, branch priority top to bottom.
    always_comb begin
        next_o = state_i;
        case (state_i)
            ST_IDLE:    next_o = start_i ? ST_LOAD : ST_IDLE;
            ST_LOAD: begin
                if (status_i.equal)     next_o = ST_DONE;
                else if (status_i.less) next_o = ST_SWAP;
                else if (status_i.msb)  next_o = ST_SUB;
                else                    next_o = ST_NORM;
            end
            ST_SWAP:    next_o = status_i.msb ? ST_SUB : ST_NORM;
            ST_NORM:    next_o = status_i.msb ? ST_SUB : ST_NORM;
            ST_SUB:     next_o = status_i.neg ? ST_RESTORE : after_remainder;
            ST_RESTORE: next_o = after_remainder;
            ST_STEP:    next_o = ST_SUB;
            ST_DONE:    next_o = ST_IDLE;
            default:    next_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/gcd_seq_state.sv
// State register: holds the present state; synchronous active-low reset
// returns it to idle. Assumes the next state arrives settled from gcd_seq_next.
module gcd_seq_state
    import gcd_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  seq_state_t next_i,
    output seq_state_t state_o
);

    // Purpose: register the next state, or idle on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_o <= ST_IDLE;
        else         state_o <= next_i;
    end

    // R1: with reset low on an edge, idle is present on the following cycle.
    p_reset_to_idle_r1: assert property (@(posedge clk_i)
        disable iff (rst_ni) 1'b1 |=> (state_o == ST_IDLE));

endmodule

// File: rtl/gcd_seq_uop.sv
// Output decode: turns the registered state into the enable word.
// One OR term per enable bit over the one-hot form of the state; depends
// only on the state, so the word moves only at clock edges.
module gcd_seq_uop
    import gcd_seq_pkg::*;
(
    input  seq_state_t       state_i,
    output logic [UOP_W-1:0] uop_o
);

    logic [NUM_STATES-1:0] state_oh;

    // Purpose: one-hot form of the present state.
    always_comb begin
        state_oh = '0;
        state_oh[state_i] = 1'b1;
    end

    // Purpose: each enable bit is active in the states its mask names.
    for (genvar b = 0; b < UOP_W; b++) begin : g_uop_bit
        localparam logic [NUM_STATES-1:0] MASK = uop_mask(b);
        assign uop_o[b] = |(state_oh & MASK);
    end

endmodule

// File: rtl/gcd_seq_ctl.sv
// Top of the GCD sequencer controller: a Moore machine that drives one
// microinstruction per state into the GCD datapath. Assumes the status
// flags are synchronous to clk_i. Synchronous active-low reset.
module gcd_seq_ctl
    import gcd_seq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             equal_i,
    input  logic             less_i,
    input  logic             msb_i,
    input  logic             neg_i,
    input  logic             cnt_zero_i,
    input  logic             rem_zero_i,
    output logic [UOP_W-1:0] uop_o
);

    seq_status_t status;
    seq_state_t  state;
    seq_state_t  next_state;

    // Purpose: gather the status flags into one record.
    assign status = '{rem_zero: rem_zero_i, cnt_zero: cnt_zero_i, neg: neg_i,
                      msb: msb_i, less: less_i, equal: equal_i};

    gcd_seq_next u_next (
        .state_i  (state),
        .start_i  (start_i),
        .status_i (status),
        .next_o   (next_state)
    );

    gcd_seq_state u_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .next_i  (next_state),
        .state_o (state)
    );

    gcd_seq_uop u_uop (
        .state_i (state),
        .uop_o   (uop_o)
    );

    // R1: idle drives no enable.
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE) |-> (uop_o == '0));

    // R2: without start, idle is held.
    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE && !start_i) |=> (state == ST_IDLE));

    // R3: equal operands win over every other flag in load.
    p_equal_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_LOAD && equal_i) |=> (uop_o[U_READY] == 1'b1));

    // R5: normalize holds until the top bit is reached.
    p_norm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_NORM && !msb_i) |=> $stable(uop_o));

    // R6: a negative partial remainder always leads to restore.
    p_neg_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_SUB && neg_i) |=> (state == ST_RESTORE));

    // R8: a step is always followed by a subtract.
    p_step_to_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_STEP) |=> (state == ST_SUB));

    // R9: ready is raised alone and lasts one cycle.
    p_ready_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_o[U_READY] |-> ($countones(uop_o) == 1));
    p_ready_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_o[U_READY] |=> (uop_o == '0));

endmodule

// File: tb/test_gcd_seq_ctl.sv
// Directed bench for the GCD sequencer controller. Inputs change 2 ns
// after a rising edge; outputs are sampled there too, away from the edge.
module test_gcd_seq_ctl;

    localparam logic [10:0] W_IDLE    = 11'h000;
    localparam logic [10:0] W_LOAD    = 11'h0A3;
    localparam logic [10:0] W_SWAP    = 11'h053;
    localparam logic [10:0] W_NORM    = 11'h206;
    localparam logic [10:0] W_SUB     = 11'h101;
    localparam logic [10:0] W_RESTORE = 11'h001;
    localparam logic [10:0] W_STEP    = 11'h30E;
    localparam logic [10:0] W_DONE    = 11'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        eq = 1'b0, lt = 1'b0, msb = 1'b0, neg = 1'b0, cz = 1'b0, rz = 1'b0;
    logic [10:0] uop;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    gcd_seq_ctl i_gcd_seq_ctl (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .equal_i(eq), .less_i(lt), .msb_i(msb), .neg_i(neg),
        .cnt_zero_i(cz), .rem_zero_i(rz), .uop_o(uop)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic [10:0] exp, input string req);
        n_checks++;
        if (uop !== exp) begin
            n_fail++;
            $display("FAIL %s: uop_o=%h expected %h", req, uop, exp);
        end
    endtask

    task automatic flags(input logic e, l, m, n, c, r);
        eq = e; lt = l; msb = m; neg = n; cz = c; rz = r;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; flags(0, 0, 0, 0, 0, 0);
        step();
        rst_n = 1'b1;
    endtask

    task automatic to_load();
        do_reset();
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic to_sub();
        to_load();
        flags(0, 0, 1, 0, 0, 0); step();
    endtask

    task automatic t_reset();
        do_reset();
        check(W_IDLE, "R1 reset idle");
        to_sub();
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check(W_IDLE, "R1 reset mid-run");
    endtask

    task automatic t_idle_start();
        do_reset();
        flags(1, 1, 1, 1, 1, 1);
        step(); check(W_IDLE, "R2 idle hold flags set");
        step(); check(W_IDLE, "R2 idle hold again");
        start = 1'b1; step(); start = 1'b0;
        check(W_LOAD, "R2 start to load");
    endtask

    task automatic t_load_branches();
        to_load(); flags(1, 1, 1, 0, 0, 0); step();
        check(W_DONE, "R3 equal wins");
        to_load(); flags(0, 1, 1, 0, 0, 0); step();
        check(W_SWAP, "R3 less to swap");
        to_load(); flags(0, 0, 1, 0, 0, 0); step();
        check(W_SUB, "R3 msb to subtract");
        to_load(); flags(0, 0, 0, 0, 0, 0); step();
        check(W_NORM, "R3 default to normalize");
    endtask

    task automatic t_swap_norm();
        to_load(); flags(0, 1, 0, 0, 0, 0); step();
        flags(0, 0, 1, 0, 0, 0); step();
        check(W_SUB, "R4 swap msb to subtract");
        to_load(); flags(0, 1, 0, 0, 0, 0); step();
        flags(0, 0, 0, 0, 0, 0); step();
        check(W_NORM, "R4 swap to normalize");
        step(); check(W_NORM, "R5 normalize holds");
        step(); check(W_NORM, "R5 normalize holds twice");
        msb = 1'b1; step();
        check(W_SUB, "R5 normalize to subtract");
    endtask

    task automatic t_subtract();
        to_sub(); flags(0, 0, 0, 1, 1, 1); step();
        check(W_RESTORE, "R6 negative to restore");
        to_sub(); flags(0, 0, 0, 0, 0, 1); step();
        check(W_STEP, "R6 count left to step");
        flags(0, 0, 0, 0, 0, 0); step();
        check(W_SUB, "R8 step to subtract");
        flags(0, 0, 0, 0, 1, 1); step();
        check(W_DONE, "R6 remainder zero to done");
        step(); check(W_IDLE, "R9 done to idle");
        to_sub(); flags(0, 0, 0, 0, 1, 0); step();
        check(W_SWAP, "R6 remainder left to swap");
    endtask

    task automatic t_restore();
        to_sub(); neg = 1'b1; step();
        flags(0, 0, 0, 0, 0, 1); step();
        check(W_STEP, "R7 restore to step");
        to_sub(); neg = 1'b1; step();
        flags(0, 0, 0, 0, 1, 1); step();
        check(W_DONE, "R7 restore to done");
        to_sub(); neg = 1'b1; step();
        flags(0, 0, 0, 0, 1, 0); step();
        check(W_SWAP, "R7 restore to swap");
    endtask

    task automatic t_mid_cycle();
        to_load();
        check(W_LOAD, "R10 load before change");
        flags(1, 1, 1, 1, 1, 1); start = 1'b1;
        #3; check(W_LOAD, "R10 load after mid-cycle change");
        flags(0, 0, 0, 0, 0, 0); start = 1'b0;
        #2; check(W_LOAD, "R10 load after second change");
        step(); check(W_NORM, "R10 edge takes last value");
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_idle_start();
        t_load_branches();
        t_swap_norm();
        t_subtract();
        t_restore();
        t_mid_cycle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule